// File: doc/BRIEF.md
# Read-Enable Latency Calibrator

This block learns how many clock cycles pass between issuing a read command and the arrival of valid read data on one data lane, and then uses that number to retime the controller's read enable. At start-up the memory controller asks it to calibrate. The block requests a write of a fixed pattern to one location and waits for that write to be acknowledged. It then issues a one-cycle read of the same location and counts cycles until the captured data matches the pattern. The rising-edge word must equal the pattern, and the falling-edge word must equal the pattern's bitwise inverse.

When the data matches, the count is stored and a done flag rises. If no match appears within a parameter limit, an error flag rises instead. After done, every read-enable pulse from the controller is reproduced exactly the stored number of cycles later. A tapped shift register does this, with the stored count selecting the tap. One instance serves one lane. A parameter narrows the comparison to the low four bits for a four-bit lane.

Top module: `rden_lat_cal`

## Requirements
- R1: While reset is held, cal_wr_req, cal_rd_req, cal_done, cal_err and rden_dly are 0 and cal_lat is 0.
- R2: A cal_start pulse seen while idle makes cal_wr_req high from the next cycle. It stays high until a cycle in which cal_wr_ack is high, and no read request is issued while it is high.
- R3: In the cycle after the one where cal_wr_ack is sampled high, cal_rd_req is high for exactly one cycle.
- R4: Call the cal_rd_req cycle cycle 0. If the first cycle k (1 <= k <= MAX_LAT) where rd_rise equals PATTERN and rd_fall equals ~PATTERN is found, then cal_done rises in cycle k+1 with cal_lat = k.
- R5: A cycle in which only one of the two words matches is not a match, and counting continues.
- R6: If no cycle 1..MAX_LAT matches, cal_err rises in cycle MAX_LAT+1 and cal_done stays 0. A match in cycle MAX_LAT itself is accepted. With the default, MAX_LAT is 15.
- R7: While cal_done is high, rden_dly is high in cycle t+cal_lat exactly when ctrl_rden was high in cycle t, including back-to-back pulses. While cal_done is low, rden_dly is 0.
- R8: After cal_done or cal_err rises, both flags and cal_lat hold until reset, and cal_start is ignored: no new write request.
- R9: wr_pat_rise carries PATTERN (default 8'hA5), and wr_pat_fall carries its bitwise inverse (8'h5A).
- R10: With NIBBLE_ONLY set, only bits [3:0] of both words are compared. Data whose low nibbles match and whose upper bits differ then counts as a match. In the full-width variant, the same data does not count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cal_start | input | 1 | Begin calibration (only acted on when idle) |
| cal_wr_ack | input | 1 | Pattern write has been issued |
| cal_wr_req | output | 1 | Request for a pattern write |
| cal_rd_req | output | 1 | One-cycle read command of the pattern location |
| wr_pat_rise | output | DATA_W | Rising-edge pattern word for the write |
| wr_pat_fall | output | DATA_W | Falling-edge pattern word (inverse) |
| rd_rise | input | DATA_W | Captured rising-edge read data |
| rd_fall | input | DATA_W | Captured falling-edge read data |
| ctrl_rden | input | 1 | Controller read enable for normal reads |
| rden_dly | output | 1 | Read enable delayed by the learned latency |
| cal_done | output | 1 | Calibration finished with a match |
| cal_err | output | 1 | No match within MAX_LAT cycles |
| cal_lat | output | CNT_W | Learned latency in cycles |

## Verification
The bench feeds half-matching data before the true match, where only the rising or only the falling word is right. A design that compared a single word would lock onto the wrong, too-short latency. It places the match at the very last allowed cycle and also withholds it entirely. An off-by-one in the limit would either raise the error for a legal latency or stall without one. A scoreboard follows single and back-to-back read-enable pulses through the tap delay, and also sends one pulse before done. A wrong tap index shows up as pulses one cycle early or late. Missing gating shows up as a spurious pulse. A nibble-mode and a full-width instance share one stimulus whose upper bits are wrong early on. A variant that compared the wrong width would report the same latency on both.

// File: rtl/rlc_pkg.sv
package rlc_pkg;
   typedef enum logic [2:0] {
      ST_IDLE,
      ST_WREQ,
      ST_RCMD,
      ST_COUNT,
      ST_LOCKED,
      ST_FAILED
   } rlc_state_t;
endpackage

// File: rtl/rlc_seq.sv
module rlc_seq #(
   parameter int MAX_LAT = 15,
   parameter int CNT_W   = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start_i,
   input  logic             wr_ack_i,
   input  logic             match_i,
   output logic             wr_req_o,
   output logic             rd_req_o,
   output logic             done_o,
   output logic             err_o,
   output logic [CNT_W-1:0] lat_o
);
   import rlc_pkg::*;

   rlc_state_t       st_q;
   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] lat_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q  <= ST_IDLE;
         cnt_q <= '0;
         lat_q <= '0;
      end else begin
         case (st_q)
            ST_IDLE:  if (start_i) st_q <= ST_WREQ;
            ST_WREQ:  if (wr_ack_i) st_q <= ST_RCMD;
            ST_RCMD: begin
               st_q  <= ST_COUNT;
               cnt_q <= CNT_W'(1);
            end
            ST_COUNT: begin
               if (match_i) begin
                  lat_q <= cnt_q;
                  st_q  <= ST_LOCKED;
               end else if (cnt_q == CNT_W'(MAX_LAT)) begin
                  st_q <= ST_FAILED;
               end else begin
                  cnt_q <= cnt_q + CNT_W'(1);
               end
            end
            ST_LOCKED: st_q <= ST_LOCKED;
            ST_FAILED: st_q <= ST_FAILED;
            default:   st_q <= ST_IDLE;
         endcase
      end
   end

   assign wr_req_o = (st_q == ST_WREQ);
   assign rd_req_o = (st_q == ST_RCMD);
   assign done_o   = (st_q == ST_LOCKED);
   assign err_o    = (st_q == ST_FAILED);
   assign lat_o    = lat_q;

   p_wr_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_req_o && !wr_ack_i) |=> wr_req_o);
   p_rd_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
      rd_req_o |=> !rd_req_o);
   p_lat_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> (lat_o >= CNT_W'(1) && lat_o <= CNT_W'(MAX_LAT)));
   p_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !(done_o && err_o));
   p_done_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> (done_o && $stable(lat_o)));
   p_err_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      err_o |=> (err_o && !wr_req_o));
endmodule

// File: rtl/rlc_match.sv
module rlc_match #(
   parameter int              DATA_W      = 8,
   parameter bit              NIBBLE_ONLY = 1'b0,
   parameter logic [DATA_W-1:0] PATTERN   = 'hA5
) (
   input  logic [DATA_W-1:0] rise_i,
   input  logic [DATA_W-1:0] fall_i,
   output logic              match_o
);
   localparam logic [DATA_W-1:0] PAT_INV = ~PATTERN;

   generate
      if (NIBBLE_ONLY) begin : g_nib
         assign match_o = (rise_i[3:0] == PATTERN[3:0]) &&
                          (fall_i[3:0] == PAT_INV[3:0]);
      end else begin : g_full
         assign match_o = (rise_i == PATTERN) && (fall_i == PAT_INV);
      end
   endgenerate
endmodule

// File: rtl/rlc_taps.sv
module rlc_taps #(
   parameter int DEPTH = 15,
   parameter int CNT_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en_i,
   input  logic [CNT_W-1:0] sel_i,
   input  logic             din_i,
   output logic             dout_o
);
   logic [DEPTH-1:0] sr_q;
   logic             tap;

   generate
      if (DEPTH == 1) begin : g_one
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) sr_q <= '0;
            else        sr_q <= din_i;
         end
      end else begin : g_many
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) sr_q <= '0;
            else        sr_q <= {sr_q[DEPTH-2:0], din_i};
         end
      end
   endgenerate

   always_comb begin
      tap = 1'b0;
      for (int i = 0; i < DEPTH; i++) begin
         if (sel_i == CNT_W'(i + 1)) tap = sr_q[i];
      end
   end

   assign dout_o = en_i & tap;
endmodule

// File: rtl/rden_lat_cal.sv
module rden_lat_cal #(
   parameter int                DATA_W      = 8,
   parameter int                MAX_LAT     = 15,
   parameter bit                NIBBLE_ONLY = 1'b0,
   parameter logic [DATA_W-1:0] PATTERN     = 'hA5,
   localparam int               CNT_W       = $clog2(MAX_LAT + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cal_start,
   input  logic              cal_wr_ack,
   output logic              cal_wr_req,
   output logic              cal_rd_req,
   output logic [DATA_W-1:0] wr_pat_rise,
   output logic [DATA_W-1:0] wr_pat_fall,
   input  logic [DATA_W-1:0] rd_rise,
   input  logic [DATA_W-1:0] rd_fall,
   input  logic              ctrl_rden,
   output logic              rden_dly,
   output logic              cal_done,
   output logic              cal_err,
   output logic [CNT_W-1:0]  cal_lat
);
   generate
      if (MAX_LAT < 1) begin : g_bad_lat
         $error("rden_lat_cal: MAX_LAT must be at least 1");
      end
      if (DATA_W < 1 || (NIBBLE_ONLY && DATA_W < 4)) begin : g_bad_w
         $error("rden_lat_cal: DATA_W too small for the chosen compare width");
      end
   endgenerate

   logic match;

   assign wr_pat_rise = PATTERN;
   assign wr_pat_fall = ~PATTERN;

   rlc_match #(
      .DATA_W(DATA_W), .NIBBLE_ONLY(NIBBLE_ONLY), .PATTERN(PATTERN)
   ) u_match (
      .rise_i(rd_rise), .fall_i(rd_fall), .match_o(match)
   );

   rlc_seq #(.MAX_LAT(MAX_LAT), .CNT_W(CNT_W)) u_seq (
      .clk(clk), .rst_n(rst_n), .start_i(cal_start), .wr_ack_i(cal_wr_ack),
      .match_i(match), .wr_req_o(cal_wr_req), .rd_req_o(cal_rd_req),
      .done_o(cal_done), .err_o(cal_err), .lat_o(cal_lat)
   );

   rlc_taps #(.DEPTH(MAX_LAT), .CNT_W(CNT_W)) u_taps (
      .clk(clk), .rst_n(rst_n), .en_i(cal_done), .sel_i(cal_lat),
      .din_i(ctrl_rden), .dout_o(rden_dly)
   );

   p_idle_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (!cal_done && !$past(cal_done)) |-> !rden_dly);
endmodule

// File: tb/rden_lat_cal_bench.sv
`timescale 1ns/1ps
module rden_lat_cal_bench;
   localparam int DW = 8;
   localparam int ML = 15;
   localparam logic [DW-1:0] PAT = 8'hA5;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic cal_start = 1'b0, cal_wr_ack = 1'b0, ctrl_rden = 1'b0;
   logic [DW-1:0] rd_rise = '0, rd_fall = '0;
   logic cal_wr_req, cal_rd_req, rden_dly, cal_done, cal_err;
   logic [DW-1:0] wr_pat_rise, wr_pat_fall;
   logic [3:0] cal_lat;
   logic nb_wr_req, nb_rd_req, nb_rden, nb_done, nb_err;
   logic [DW-1:0] nb_pr, nb_pf;
   logic [3:0] nb_lat;

   int nchk = 0, nfail = 0, cyc = 0, cur_lat = 0;
   int sbq[$];
   bit finished = 0;

   always #2.5 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   rden_lat_cal #(.DATA_W(DW), .MAX_LAT(ML), .PATTERN(PAT)) u_rden_lat_cal (
      .clk(clk), .rst_n(rst_n), .cal_start(cal_start), .cal_wr_ack(cal_wr_ack),
      .cal_wr_req(cal_wr_req), .cal_rd_req(cal_rd_req),
      .wr_pat_rise(wr_pat_rise), .wr_pat_fall(wr_pat_fall),
      .rd_rise(rd_rise), .rd_fall(rd_fall), .ctrl_rden(ctrl_rden),
      .rden_dly(rden_dly), .cal_done(cal_done), .cal_err(cal_err), .cal_lat(cal_lat)
   );

   rden_lat_cal #(.DATA_W(DW), .MAX_LAT(ML), .NIBBLE_ONLY(1'b1), .PATTERN(PAT)) u_rden_lat_cal_nib (
      .clk(clk), .rst_n(rst_n), .cal_start(cal_start), .cal_wr_ack(cal_wr_ack),
      .cal_wr_req(nb_wr_req), .cal_rd_req(nb_rd_req),
      .wr_pat_rise(nb_pr), .wr_pat_fall(nb_pf),
      .rd_rise(rd_rise), .rd_fall(rd_fall), .ctrl_rden(ctrl_rden),
      .rden_dly(nb_rden), .cal_done(nb_done), .cal_err(nb_err), .cal_lat(nb_lat)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      nchk++;
      if (!ok) begin
         nfail++;
         $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
      end
   endtask

   // scoreboard monitor for delayed read enables
   always @(negedge clk) begin
      bit due;
      due = (sbq.size() > 0) && (sbq[0] == cyc);
      if (due || rden_dly) begin
         nchk++;
         if (due != rden_dly) begin
            nfail++;
            $display("FAIL R7 rden_dly actual=%0d expected=%0d (cycle %0d)", rden_dly, due, cyc);
         end
         if (due) void'(sbq.pop_front());
      end
   end

   task automatic drive_rden(input bit v);
      @(negedge clk);
      ctrl_rden = v;
      if (v) sbq.push_back(cyc + cur_lat);
   endtask

   task automatic set_data(input logic [DW-1:0] r, input logic [DW-1:0] f);
      rd_rise = r;
      rd_fall = f;
   endtask

   task automatic do_reset();
      rst_n = 1'b0;
      cal_start = 0; cal_wr_ack = 0; ctrl_rden = 0;
      set_data('0, '0);
      sbq.delete();
      cur_lat = 0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
   endtask

   // ends at the negedge of the read-command cycle (cycle 0)
   task automatic to_read();
      @(negedge clk); cal_start = 1;
      @(negedge clk); cal_start = 0;
      chk(cal_wr_req === 1'b1, "R2 wr_req after start", cal_wr_req, 1);
      @(negedge clk);
      chk(cal_wr_req === 1'b1 && cal_rd_req === 1'b0, "R2 wr_req held without ack", cal_wr_req, 1);
      cal_wr_ack = 1;
      @(negedge clk); cal_wr_ack = 0;
      chk(cal_rd_req === 1'b1 && cal_wr_req === 1'b0, "R3 rd_req after ack", cal_rd_req, 1);
   endtask

   initial begin
      // ---------------- reset state
      rst_n = 1'b0;
      repeat (2) @(negedge clk);
      chk(cal_wr_req === 0 && cal_rd_req === 0 && rden_dly === 0, "R1 req/rden in reset", cal_wr_req, 0);
      chk(cal_done === 0 && cal_err === 0 && cal_lat === 0, "R1 flags in reset", cal_lat, 0);
      chk(wr_pat_rise === 8'hA5 && wr_pat_fall === 8'h5A, "R9 pattern ports", wr_pat_fall, 8'h5A);
      do_reset();

      // ---------------- test A: latency 5, partial matches before it
      to_read();
      ctrl_rden = 1;               // pulse before done: must never emerge (R7)
      for (int k = 1; k <= 5; k++) begin
         @(negedge clk);
         ctrl_rden = 0;
         if (k == 1) chk(cal_rd_req === 0, "R3 rd_req one cycle", cal_rd_req, 0);
         if (k == 2)      set_data(PAT, 8'h00);   // R5 rising only
         else if (k == 3) set_data(8'h00, ~PAT);  // R5 falling only
         else if (k == 5) set_data(PAT, ~PAT);
         else             set_data(8'h00, 8'h00);
         if (k == 4) chk(cal_done === 0, "R5 partial match ignored", cal_done, 0);
         if (k == 5) chk(rden_dly === 0, "R7 no output before done", rden_dly, 0);
      end
      @(negedge clk);
      set_data(8'h00, 8'h00);
      chk(cal_done === 1 && cal_err === 0, "R4 done after match", cal_done, 1);
      chk(cal_lat === 5, "R4 latency 5", cal_lat, 5);
      cur_lat = 5;
      // R8: restart ignored
      cal_start = 1;
      @(negedge clk); cal_start = 0;
      @(negedge clk);
      chk(cal_wr_req === 0, "R8 start ignored after done", cal_wr_req, 0);
      // R7 scoreboard: single, back-to-back
      drive_rden(1); drive_rden(0); drive_rden(0);
      drive_rden(1); drive_rden(1); drive_rden(0);
      repeat (10) @(negedge clk);
      chk(sbq.size() == 0, "R7 all delayed pulses seen", sbq.size(), 0);
      chk(cal_done === 1 && cal_lat === 5, "R8 latency held", cal_lat, 5);

      // ---------------- test B: no match -> error
      do_reset();
      to_read();
      for (int k = 1; k <= ML; k++) begin
         @(negedge clk);
         set_data(8'h00, 8'h00);
         if (k == ML) chk(cal_err === 0, "R6 no error before limit", cal_err, 0);
      end
      @(negedge clk);
      set_data(PAT, ~PAT);
      chk(cal_err === 1 && cal_done === 0, "R6 error after limit", cal_err, 1);
      cal_start = 1;
      @(negedge clk); cal_start = 0;
      @(negedge clk);
      chk(cal_done === 0 && cal_err === 1 && cal_wr_req === 0, "R8 error held, late match ignored", cal_done, 0);

      // ---------------- test C: match exactly at the limit
      do_reset();
      to_read();
      for (int k = 1; k <= ML; k++) begin
         @(negedge clk);
         if (k == ML) set_data(PAT, ~PAT); else set_data(8'h00, 8'h00);
      end
      @(negedge clk);
      set_data(8'h00, 8'h00);
      chk(cal_done === 1 && cal_err === 0 && cal_lat === ML, "R6 match at limit accepted", cal_lat, ML);
      cur_lat = ML;
      drive_rden(1); drive_rden(1); drive_rden(0);
      repeat (ML + 4) @(negedge clk);
      chk(sbq.size() == 0, "R7 pulses at max delay", sbq.size(), 0);

      // ---------------- test D: nibble vs full width
      do_reset();
      to_read();
      for (int k = 1; k <= 6; k++) begin
         @(negedge clk);
         if (k == 3)      set_data(8'hF5, 8'hAA);  // low nibbles match, upper wrong
         else if (k == 6) set_data(PAT, ~PAT);
         else             set_data(8'h00, 8'h00);
         if (k == 4) begin
            chk(nb_done === 1 && nb_lat === 3, "R10 nibble variant latency 3", nb_lat, 3);
            chk(cal_done === 0, "R10 full variant rejects upper mismatch", cal_done, 0);
         end
      end
      @(negedge clk);
      set_data(8'h00, 8'h00);
      chk(cal_done === 1 && cal_lat === 6, "R10 full variant latency 6", cal_lat, 6);
      chk(nb_lat === 3, "R8 nibble latency held", nb_lat, 3);

      if (!finished) begin
         finished = 1;
         $display("%0d/%0d checks passed", nchk - nfail, nchk);
         $finish;
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         finished = 1;
         nchk++; nfail++;
         $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
         $display("%0d/%0d checks passed", nchk - nfail, nchk);
         $finish;
      end
   end
endmodule